// File: doc/BRIEF.md
# Buffer Descriptor Ring Walker

This engine serves one direction of a packet DMA channel. It walks a ring of 8-byte buffer descriptors that software has placed back to back in system memory. No descriptor holds a link to the next one. The engine fetches the descriptor at its current address and looks at the ownership flag. When the engine owns the descriptor, it hands the buffer pointer and length to a data mover. When the mover reports completion, the engine writes the status half-word back with ownership cleared and the mover's completion code inserted. It then steps to the next descriptor. A wrap flag in a descriptor sends the cursor back to the ring base instead of stepping forward.

Descriptor layout, as a 64-bit little-endian word:
- bits [63:48] hold status and control. Bit 63 is ownership (1 = engine owns it) and bit 61 is wrap.
- bits [47:32] hold the buffer length.
- bits [31:0] hold the buffer pointer.

Software programs the engine through a small register write port:
- code 0 sets the ring base,
- code 1 sets the enable (bit 0),
- code 2 sets the poll delay.

Rings are expected to hold at least four descriptors, and a transmit ring holds at most 65536. Memory traffic uses a valid/ready request channel with at most one read in flight, and a read-data response.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, and for as long as the enable bit has not been set, neither `mem_req_valid` nor `mv_valid` is raised.
- R2: A register write with code 0 loads the ring base, and address bits [2:0] are dropped. A write with code 1 and bit 0 set enables the engine. The first request after enabling is a read (`mem_req_write`=0) at the base address.
- R3: A descriptor whose bit 63 is 0 produces no mover request. With poll delay D (register code 2), the engine re-reads the same address, and that read request is raised on the (D+2)-th clock after the clock that carried the read response.
- R4: For an owned descriptor, the mover request presents `mv_ptr` equal to descriptor bits [31:0] and `mv_len` equal to bits [47:32].
- R5: The write-back happens only after `mv_done`. It is a write to the descriptor's own address with byte enables 0xC0. Its data bits [63:48] are {0, descriptor bits [62:56], `mv_status`}.
- R6: After the write-back is accepted, the next read is at the descriptor address plus 8. All request addresses are 8-byte aligned.
- R7: After the write-back of a descriptor whose bit 61 is set, the next read is at the ring base.
- R8: A base write (code 0) while the engine is enabled has no effect on any later descriptor address.
- R9: Clearing the enable bit stops the engine at its next descriptor boundary. After that, no requests are made. Setting the enable bit again restarts the walk at the ring base, not at the stopped position.
- R10: At most one read is outstanding. While `mem_req_valid` waits for `mem_req_ready`, the request's address, direction and data stay unchanged.
- R11: `mv_valid` stays high with stable pointer and length until `mv_ready`. A mover request and a memory request are never raised in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register code: 0 base, 1 enable, 2 poll delay |
| cfg_wdata | input | AW | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Descriptor address |
| mem_req_wdata | output | 64 | Write data (status in [63:48]) |
| mem_req_be | output | 8 | Byte enables for writes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data (one descriptor) |
| mv_valid | output | 1 | Data mover request valid |
| mv_ready | input | 1 | Data mover accepted the request |
| mv_ptr | output | 32 | Buffer pointer for the mover |
| mv_len | output | 16 | Buffer length for the mover |
| mv_done | input | 1 | Mover completion pulse |
| mv_status | input | ST_W | Mover completion code |

## Verification
The bench's reference model runs on every falling edge. It accounts for the registers on each path:
- The mover request is due on the clock after the one that consumes the read response.
- The write-back is due on the clock after the one that consumes `mv_done`.
- A re-poll read is due exactly D+2 clocks after the response clock.

The model checks each handshake against the transaction it expects. It also rejects any memory or mover request that appears in a cycle where none is allowed. Register writes are driven just after a rising edge, so their effect lands on a known edge. Disables are issued only while the engine is polling with a delay of at least 3, so the stop boundary is unambiguous.

// File: rtl/dring_pkg.sv
package dring_pkg;
  localparam int DESC_BYTES = 8;
  localparam int DESC_W     = 64;
  localparam int OWN_POS    = 63;
  localparam int WRAP_POS   = 61;
  localparam int STAT_LSB   = 48;
  localparam int LEN_LSB    = 32;
  localparam int LEN_W      = 16;
  localparam int PTR_W      = 32;
  localparam int STAT_W     = 16;
  localparam logic [7:0] WB_BE = 8'hC0;

  localparam logic [1:0] CFG_BASE = 2'd0;
  localparam logic [1:0] CFG_CTRL = 2'd1;
  localparam logic [1:0] CFG_POLL = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_POLL,
    S_MV_REQ,
    S_MV_WAIT,
    S_WB_REQ
  } walk_state_e;
endpackage

// File: rtl/dring_cfg.sv
module dring_cfg
  import dring_pkg::*;
#(
  parameter int AW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] base_q,
  output logic          en_q,
  output logic [PW-1:0] delay_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      en_q    <= 1'b0;
      delay_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        CFG_BASE: if (!en_q) base_q <= {cfg_wdata[AW-1:3], 3'b000};
        CFG_CTRL: en_q <= cfg_wdata[0];
        CFG_POLL: delay_q <= cfg_wdata[PW-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dring_cursor.sv
module dring_cursor
  import dring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] base,
  input  logic          load,
  input  logic          step,
  input  logic          wrap,
  output logic [AW-1:0] cur
);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= base;
    else if (step) cur <= wrap ? base : cur + STRIDE;
  end
endmodule

// File: rtl/dring_poll_timer.sv
module dring_poll_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [PW-1:0] delay,
  output logic          expired
);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (start)      cnt <= delay;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dring_ctrl.sv
module dring_ctrl
  import dring_pkg::*;
#(
  parameter int AW   = 32,
  parameter int ST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              poll_expired,
  input  logic [AW-1:0]     cur_addr,
  output logic              poll_start,
  output logic              cur_load,
  output logic              cur_step,
  output logic              wrap_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DESC_W-1:0] mem_req_wdata,
  output logic [7:0]        mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [PTR_W-1:0]  mv_ptr,
  output logic [LEN_W-1:0]  mv_len,
  input  logic              mv_done,
  input  logic [ST_W-1:0]   mv_status
);
  walk_state_e       state, state_d;
  logic [DESC_W-1:0] desc_q;
  logic [STAT_W-1:0] wb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      desc_q <= '0;
      wb_q   <= '0;
    end else begin
      state <= state_d;
      if (state == S_RD_WAIT && mem_rsp_valid) desc_q <= mem_rsp_data;
      if (state == S_MV_WAIT && mv_done)
        wb_q <= {1'b0, desc_q[OWN_POS-1:STAT_LSB+ST_W], mv_status};
    end
  end

  always_comb begin
    state_d    = state;
    poll_start = 1'b0;
    cur_load   = 1'b0;
    cur_step   = 1'b0;
    case (state)
      S_IDLE: if (en) begin
        state_d  = S_RD_REQ;
        cur_load = 1'b1;
      end
      S_RD_REQ:  if (mem_req_ready) state_d = S_RD_WAIT;
      S_RD_WAIT: if (mem_rsp_valid) begin
        if (mem_rsp_data[OWN_POS]) state_d = S_MV_REQ;
        else begin
          state_d    = S_POLL;
          poll_start = 1'b1;
        end
      end
      S_POLL:    if (poll_expired) state_d = en ? S_RD_REQ : S_IDLE;
      S_MV_REQ:  if (mv_ready) state_d = S_MV_WAIT;
      S_MV_WAIT: if (mv_done) state_d = S_WB_REQ;
      S_WB_REQ:  if (mem_req_ready) begin
        cur_step = 1'b1;
        state_d  = en ? S_RD_REQ : S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign wrap_hit      = desc_q[WRAP_POS];
  assign mem_req_valid = (state == S_RD_REQ) || (state == S_WB_REQ);
  assign mem_req_write = (state == S_WB_REQ);
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = {wb_q, {(DESC_W-STAT_W){1'b0}}};
  assign mem_req_be    = mem_req_write ? WB_BE : 8'hFF;
  assign mv_valid      = (state == S_MV_REQ);
  assign mv_ptr        = desc_q[PTR_W-1:0];
  assign mv_len        = desc_q[LEN_LSB+LEN_W-1:LEN_LSB];
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
  import dring_pkg::*;
#(
  parameter int AW   = 32,
  parameter int PW   = 16,
  parameter int ST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [AW-1:0]     mem_req_addr,
  output logic [DESC_W-1:0] mem_req_wdata,
  output logic [7:0]        mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [PTR_W-1:0]  mv_ptr,
  output logic [LEN_W-1:0]  mv_len,
  input  logic              mv_done,
  input  logic [ST_W-1:0]   mv_status
);
  logic [AW-1:0] base_q, cur;
  logic          en_q;
  logic [PW-1:0] delay_q;
  logic          poll_start, poll_expired, cur_load, cur_step, wrap_hit;

  dring_cfg #(.AW(AW), .PW(PW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .base_q(base_q), .en_q(en_q), .delay_q(delay_q)
  );

  dring_cursor #(.AW(AW)) u_cursor (
    .clk(clk), .rst(rst), .base(base_q), .load(cur_load),
    .step(cur_step), .wrap(wrap_hit), .cur(cur)
  );

  dring_poll_timer #(.PW(PW)) u_poll (
    .clk(clk), .rst(rst), .start(poll_start), .delay(delay_q),
    .expired(poll_expired)
  );

  dring_ctrl #(.AW(AW), .ST_W(ST_W)) u_ctrl (
    .clk(clk), .rst(rst), .en(en_q), .poll_expired(poll_expired),
    .cur_addr(cur), .poll_start(poll_start), .cur_load(cur_load),
    .cur_step(cur_step), .wrap_hit(wrap_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_ptr(mv_ptr),
    .mv_len(mv_len), .mv_done(mv_done), .mv_status(mv_status)
  );
endmodule

// File: rtl/dring_walker_chk.sv
module dring_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [63:0]   mem_req_wdata,
  input logic [7:0]    mem_req_be,
  input logic          mem_rsp_valid,
  input logic          mv_valid,
  input logic          mv_ready,
  input logic [31:0]   mv_ptr,
  input logic [15:0]   mv_len
);
  logic rd_pend;

  always_ff @(posedge clk) begin
    if (rst) rd_pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_pend <= 1'b1;
    else if (mem_rsp_valid) rd_pend <= 1'b0;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req_valid && !mv_valid));

  p_wb_clears_own_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> (!mem_req_wdata[63] && mem_req_be == 8'hC0));

  p_addr_aligned_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  p_one_read_r10: assert property (@(posedge clk) disable iff (rst)
    rd_pend |-> !mem_req_valid);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_mv_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_ptr) && $stable(mv_len)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(mv_valid && mem_req_valid));
endmodule

bind desc_ring_walker dring_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
  .mem_rsp_valid(mem_rsp_valid), .mv_valid(mv_valid), .mv_ready(mv_ready),
  .mv_ptr(mv_ptr), .mv_len(mv_len)
);

// File: tb/tb_desc_ring_walker.sv
module tb_desc_ring_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic [7:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mv_valid;
  logic        mv_ready = 1'b0;
  logic [31:0] mv_ptr;
  logic [15:0] mv_len;
  logic        mv_done = 1'b0;
  logic [7:0]  mv_status = '0;

  desc_ring_walker dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_ptr(mv_ptr), .mv_len(mv_len),
    .mv_done(mv_done), .mv_status(mv_status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, failed = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference state
  logic [63:0] mem [0:31];
  int          phase = 0;        // 0 none, 1 read, 2 mover, 3 write-back
  logic [31:0] exp_addr = '0, cur_addr = '0, base_m = '0;
  string       exp_tag = "R2";
  bit          en_m = 0;
  logic [63:0] cur_desc = '0;
  bit          rsp_pend = 0, prev_valid = 0;
  int          poll_ref = -1, poll_d = 0, done_cnt = 0;
  logic [7:0]  done_stat = '0;
  int          n_proc = 0, n_unowned = 0, n_req = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int idx(input logic [31:0] a);
    return int'(a[7:3]);
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    mv_done       = 1'b0;
    if (!finished && cyc > 60000) begin
      finished = 1;
      chk(0, "watchdog", "run did not finish", cyc, 60000);
      summary();
      $finish;
    end
    if (!rst) begin
      if (rsp_pend) begin
        rsp_pend      = 0;
        cur_desc      = mem[idx(cur_addr)];
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = cur_desc;
        if (cur_desc[63]) phase = 2;
        else begin
          phase    = en_m ? 1 : 0;
          poll_ref = cyc;
          n_unowned++;
        end
      end
      if (done_cnt > 0) begin
        done_cnt--;
        if (done_cnt == 0) begin
          mv_done   = 1'b1;
          mv_status = done_stat;
          phase     = 3;
        end
      end
      // memory channel
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid) begin
        n_req++;
        if (!prev_valid && poll_ref >= 0)
          chk(cyc - poll_ref == poll_d + 2, "R3", "re-poll delay", cyc - poll_ref, poll_d + 2);
        if (!prev_valid) poll_ref = -1;
        chk(mem_req_write ? phase == 3 : phase == 1, "R10", "memory request allowed now",
            {mem_req_write, 31'd0}, phase);
        if (mem_req_ready) begin
          if (!mem_req_write) begin
            chk(mem_req_addr == exp_addr, exp_tag, "read address", mem_req_addr, exp_addr);
            cur_addr = mem_req_addr;
            rsp_pend = 1;
            phase    = 0;
          end else begin
            chk(mem_req_addr == cur_addr, "R5", "write-back address", mem_req_addr, cur_addr);
            chk(mem_req_be == 8'hC0, "R5", "write-back enables", mem_req_be, 8'hC0);
            chk(mem_req_wdata[63:48] == {1'b0, cur_desc[62:56], done_stat}, "R5",
                "write-back status", mem_req_wdata[63:48], {1'b0, cur_desc[62:56], done_stat});
            mem[idx(cur_addr)][63:48] = mem_req_wdata[63:48];
            if (cur_desc[61]) begin exp_addr = base_m;       exp_tag = "R7"; end
            else              begin exp_addr = cur_addr + 8; exp_tag = "R6"; end
            phase = en_m ? 1 : 0;
            n_proc++;
          end
        end
      end
      prev_valid = mem_req_valid && !mem_req_ready;
      // mover channel
      mv_ready = cyc[0];
      if (mv_valid) begin
        chk(phase == 2, "R3", "mover request allowed now", 1, phase == 2);
        if (mv_ready) begin
          chk(mv_ptr == cur_desc[31:0], "R4", "mover pointer", mv_ptr, cur_desc[31:0]);
          chk(mv_len == cur_desc[47:32], "R4", "mover length", mv_len, cur_desc[47:32]);
          done_cnt  = 2;
          done_stat = mv_ptr[7:0] ^ 8'h5A;
          phase     = 0;
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    if (a == 2'd0 && !en_m) base_m = {d[31:3], 3'b000};
    if (a == 2'd2) poll_d = int'(d[15:0]);
    if (a == 2'd1) begin
      if (d[0] && !en_m) begin
        exp_addr = base_m; exp_tag = "R9"; phase = 1; poll_ref = -1;
      end
      if (!d[0]) begin
        if (phase == 1) phase = 0;
        poll_ref = -1;
      end
      en_m = d[0];
    end
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_until(input int procs, input int unowned);
    while (n_proc < procs || n_unowned < unowned) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++)
      mem[8 + i] = {16'h8C00 | (i == 3 ? 16'h2000 : 16'h0000), 16'(16'h100 + 16 * i),
                    32'h1000_0000 + 32'(i * 256)};
    mem[16] = {16'h8100, 16'h0040, 32'h2000_0010};
    mem[17] = {16'hA300, 16'h0080, 32'h2000_0020};
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1: quiet after reset and while only configured
    repeat (3) @(negedge clk);
    chk(!mem_req_valid && !mv_valid, "R1", "no request after reset", {mem_req_valid, mv_valid}, 0);
    cfg_write(2'd2, 32'd3);
    cfg_write(2'd0, 32'h44);
    n_req = 0;
    repeat (6) @(negedge clk);
    chk(n_req == 0, "R1", "no request while disabled", n_req, 0);

    // R2, R4, R5, R6, R7, R3: walk four descriptors, wrap onto an unowned one
    cfg_write(2'd1, 32'd1);
    exp_tag = "R2";
    wait_until(4, 2);
    chk(n_proc == 4, "R7", "descriptors done before wrap", n_proc, 4);

    // R8: base write while enabled is ignored; software re-arms descriptor 0
    cfg_write(2'd0, 32'h80);
    @(posedge clk); #1;
    mem[8][63] = 1'b1;
    wait_until(5, n_unowned + 2);
    chk(exp_addr == 32'h48, "R6", "walker parked on next slot", exp_addr, 32'h48);

    // R9: disable, stay quiet, re-enable restarts at base (still 0x40, R8)
    cfg_write(2'd1, 32'd0);
    n_req = 0;
    repeat (20) @(negedge clk);
    chk(n_req == 0, "R9", "no request after disable", n_req, 0);
    @(posedge clk); #1;
    mem[8][63] = 1'b1;
    cfg_write(2'd1, 32'd1);
    wait_until(6, n_unowned + 1);
    chk(base_m == 32'h40, "R8", "base kept", base_m, 32'h40);
    cfg_write(2'd1, 32'd0);
    repeat (12) @(posedge clk);

    // second ring: new base accepted while disabled, zero poll delay, early wrap
    cfg_write(2'd0, 32'h80);
    cfg_write(2'd2, 32'd0);
    cfg_write(2'd1, 32'd1);
    exp_tag = "R2";
    wait_until(8, n_unowned + 3);
    chk(n_proc == 8, "R7", "second ring processed", n_proc, 8);

    finished = 1;
    summary();
    $finish;
  end
endmodule